// File: doc/BRIEF.md
# GPIO Edge-Event Status Unit

This block samples 81 general-purpose input pins and captures edge events in sticky status bits. Each pin has its own rising-edge enable and falling-edge enable, both held in read/write mask words. A pin whose enabled edge occurs has its status bit set. The bit stays set until software writes a one to that bit position.

Every pin passes through a two-flop synchronizer. An edge is detected by comparing the synchronized level with its value one clock earlier.

Status bits drive three interrupt lines:
- Pin 0 has a dedicated line.
- Pin 1 has a dedicated line.
- Pins 2 to 80 share one combined request.

Register reads are combinational from the address. Writes take effect at the clock edge on which the write enable is high.

Top module: `gpio_edge_stat`

## Requirements
- R1: After reset, every status bit, every rising-enable bit and every falling-enable bit reads 0, and all three interrupt outputs are low.
- R2: A low-to-high transition on a pin whose rising-enable bit is 1 sets that pin's status bit. A transition on a pin whose matching enable is 0 leaves its status bit unchanged.
- R3: A high-to-low transition on a pin whose falling-enable bit is 1 sets that pin's status bit.
- R4: With both enables set for a pin, either transition direction sets its status bit.
- R5: A set status bit stays set while no one is written to it. Writing 0 to a status bit has no effect.
- R6: Writing 1 to a status bit clears it. Other bits of the same word are untouched.
- R7: When an edge event and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R8: `irq_pin0_o` equals status bit of pin 0. `irq_pin1_o` equals status bit of pin 1.
- R9: `irq_shared_o` is high exactly when any status bit of pins 2 to 80 is set.
- R10: The register map is as follows. Any other address reads 0.
  - Rising-enable words are at 0x00, 0x04 and 0x08.
  - Falling-enable words are at 0x0C, 0x10 and 0x14.
  - Status words are at 0x48, 0x4C and 0x50.
  - Within each group, word k bit j stands for pin 32*k+j.
- R11: In the third word of every group, bits 31:17 have no pin behind them. They read 0 and ignore writes.
- R12: A pin transition driven before clock edge 1 is not visible in status after edge 2. It is visible after edge 3, because of the two synchronizer stages plus the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| pin_i | input | 81 | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_pin0_o | output | 1 | Interrupt for pin 0 |
| irq_pin1_o | output | 1 | Interrupt for pin 1 |
| irq_shared_o | output | 1 | Combined interrupt for pins 2 to 80 |

## Verification
The bound checker covers several rules on every cycle:
- Status bits are sticky.
- A write of one clears a bit.
- A bit never sets without a detected event, and an event always wins over a simultaneous clear.
- Events only arise where the synchronizer saw a change.
- The three interrupt lines follow the status bits.

Some behaviour is shown only by the bench's scenarios, not by the per-cycle checks:
- The mapping of enables to edge direction.
- The address map and the dead upper bits.
- The exact three-edge latency.
- Agreement with an independent model under random pin, mask and clear traffic.

// File: rtl/gpio_es_pkg.sv
package gpio_es_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] RISE_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h48;

    function automatic int unsigned words_for(input int unsigned n);
        return (n + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/gpio_es_sync.sv
module gpio_es_sync #(
    parameter int unsigned W = 81
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] level;
        logic [W-1:0] hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.meta  = pin_i;
        st_d.level = st_q.meta;
        st_d.hist  = st_q.level;
        rise_o     = st_q.level & ~st_q.hist;
        fall_o     = ~st_q.level & st_q.hist;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/gpio_es_mask.sv
module gpio_es_mask
    import gpio_es_pkg::*;
#(
    parameter int unsigned       W    = 81,
    parameter int unsigned       NW   = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'h00
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [W-1:0]      mask_o,
    output logic [WORD_W-1:0] rdata_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic [NW-1:0] hit;

    for (genvar w = 0; w < NW; w++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BASE + 4 * w);
        assign hit[w] = (addr_i == OFF);
    end

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int i = 0; i < W; i++) begin
            if (wr_en_i && hit[i / WORD_W]) st_d.mask[i] = wdata_i[i % WORD_W];
            if (hit[i / WORD_W])            rdata_o[i % WORD_W] = st_q.mask[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/gpio_es_status.sv
module gpio_es_status
    import gpio_es_pkg::*;
#(
    parameter int unsigned       W    = 81,
    parameter int unsigned       NW   = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'h48
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [W-1:0]      evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [W-1:0]      stat_o,
    output logic [W-1:0]      clr_o,
    output logic [WORD_W-1:0] rdata_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NW-1:0] hit;

    for (genvar w = 0; w < NW; w++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BASE + 4 * w);
        assign hit[w] = (addr_i == OFF);
    end

    always_comb begin
        clr_o   = '0;
        rdata_o = '0;
        for (int i = 0; i < W; i++) begin
            clr_o[i] = wr_en_i && hit[i / WORD_W] && wdata_i[i % WORD_W];
            if (hit[i / WORD_W]) rdata_o[i % WORD_W] = st_q.stat[i];
        end
        // an event arriving with a clear keeps the bit set
        st_d.stat = (st_q.stat & ~clr_o) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat
    import gpio_es_pkg::*;
#(
    parameter int unsigned NUM_PINS = 81
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    output logic                irq_pin0_o,
    output logic                irq_pin1_o,
    output logic                irq_shared_o
);
    localparam int unsigned       NUM_WORDS = words_for(NUM_PINS);
    localparam logic [ADDR_W-1:0] FALL_BASE = ADDR_W'(RISE_BASE + 4 * NUM_WORDS);

    logic [NUM_PINS-1:0] rise, fall, ren, fen, evt, stat_q, clr;
    logic [WORD_W-1:0]   rd_rise, rd_fall, rd_stat;

    gpio_es_sync #(.W(NUM_PINS)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_es_mask #(.W(NUM_PINS), .NW(NUM_WORDS), .BASE(RISE_BASE)) rise_en_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .mask_o  (ren),
        .rdata_o (rd_rise)
    );

    gpio_es_mask #(.W(NUM_PINS), .NW(NUM_WORDS), .BASE(FALL_BASE)) fall_en_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .mask_o  (fen),
        .rdata_o (rd_fall)
    );

    assign evt = (rise & ren) | (fall & fen);

    gpio_es_status #(.W(NUM_PINS), .NW(NUM_WORDS), .BASE(STAT_BASE)) stat_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (evt),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .stat_o  (stat_q),
        .clr_o   (clr),
        .rdata_o (rd_stat)
    );

    assign rdata_o      = rd_rise | rd_fall | rd_stat;
    assign irq_pin0_o   = stat_q[0];
    assign irq_pin1_o   = stat_q[1];
    assign irq_shared_o = |stat_q[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_es_chk.sv
module gpio_es_chk #(
    parameter int unsigned W = 81
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] stat_i,
    input logic [W-1:0] evt_i,
    input logic [W-1:0] clr_i,
    input logic [W-1:0] rise_i,
    input logic [W-1:0] fall_i,
    input logic         irq0_i,
    input logic         irq1_i,
    input logic         irqs_i
);
    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(stat_i & ~clr_i)) == $past(stat_i & ~clr_i)));

    assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(clr_i & ~evt_i)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(evt_i)) == $past(evt_i)));

    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & ~$past(stat_i | evt_i)) == '0));

    assert_evt_needs_edge_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_i & ~(rise_i | fall_i)) == '0));

    assert_one_direction_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise_i & fall_i) == '0));

    assert_irq_pins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq0_i == stat_i[0]) && (irq1_i == stat_i[1]));

    assert_irq_shared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irqs_i == (|stat_i[W-1:2]));
endmodule

bind gpio_edge_stat gpio_es_chk #(.W(NUM_PINS)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_q),
    .evt_i  (evt),
    .clr_i  (clr),
    .rise_i (rise),
    .fall_i (fall),
    .irq0_i (irq_pin0_o),
    .irq1_i (irq_pin1_o),
    .irqs_i (irq_shared_o)
);

// File: tb/gpio_edge_stat_tb_top.sv
module gpio_edge_stat_tb_top;
    localparam int NP = 81;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic          wr_en;
    logic [7:0]    addr;
    logic [31:0]   wdata, rdata;
    logic          irq0, irq1, irqs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [NP-1:0] exp_stat, ren_m, fen_m;

    always #5 clk = ~clk;

    gpio_edge_stat dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pin_i        (pins),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .irq_pin0_o   (irq0),
        .irq_pin1_o   (irq1),
        .irq_shared_o (irqs)
    );

    function automatic logic [31:0] slice(logic [NP-1:0] v, int k);
        logic [95:0] e;
        e = 96'(v);
        return e[k*32 +: 32];
    endfunction

    function automatic logic [NP-1:0] put(logic [NP-1:0] v, int k, logic [31:0] d);
        logic [95:0] e;
        e = 96'(v);
        e[k*32 +: 32] = d;
        return e[NP-1:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic mask_wr(bit is_fall, int k, logic [31:0] d);
        bus_wr(8'((is_fall ? 8'h0C : 8'h00) + 4 * k), d);
        if (is_fall) fen_m = put(fen_m, k, d);
        else         ren_m = put(ren_m, k, d);
    endtask

    task automatic clr_wr(int k, logic [31:0] d);
        bus_wr(8'(8'h48 + 4 * k), d);
        exp_stat = put(exp_stat, k, slice(exp_stat, k) & ~d);
    endtask

    task automatic drive_pins(logic [NP-1:0] nv);
        @(negedge clk);
        exp_stat = exp_stat | (ren_m & nv & ~pins) | (fen_m & ~nv & pins);
        pins = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        for (int k = 0; k < 3; k++) begin
            bus_rd(8'(8'h48 + 4 * k), d);
            check(req, d, slice(exp_stat, k));
        end
        check({req, " irq0 (R8)"}, {31'b0, irq0}, {31'b0, exp_stat[0]});
        check({req, " irq1 (R8)"}, {31'b0, irq1}, {31'b0, exp_stat[1]});
        check({req, " shared (R9)"}, {31'b0, irqs}, {31'b0, |exp_stat[NP-1:2]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0]   d;
        logic [NP-1:0] nv;
        int unsigned   seed_init;
        seed_init = $urandom(32'd4711);
        rst_n = 1'b0; pins = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        exp_stat = '0; ren_m = '0; fen_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1");
        for (int k = 0; k < 6; k++) begin
            bus_rd(8'(4 * k), d);
            check("R1 enable reset", d, 32'h0);
        end

        // R10 map and R11 dead bits of masks
        mask_wr(1'b0, 0, 32'hA5A5_0F0F);
        bus_rd(8'h00, d); check("R10 rise word0", d, 32'hA5A5_0F0F);
        mask_wr(1'b1, 2, 32'hFFFF_FFFF);
        bus_rd(8'h14, d); check("R11 fall word2", d, 32'h0001_FFFF);
        bus_rd(8'h10, d); check("R10 fall word1 untouched", d, 32'h0);
        mask_wr(1'b0, 2, 32'h1234_5678);
        bus_rd(8'h08, d); check("R11 rise word2", d, 32'h0000_5678);
        bus_rd(8'h40, d); check("R10 unmapped", d, 32'h0);
        for (int k = 0; k < 3; k++) begin
            mask_wr(1'b0, k, 32'h0);
            mask_wr(1'b1, k, 32'h0);
        end

        // R2 rising enable only for pin 5
        mask_wr(1'b0, 0, 32'h0000_0020);
        drive_pins(pins | (NP'(1) << 5) | (NP'(1) << 6));
        bus_rd(8'h48, d); check("R2 rise pin5 only", d, 32'h0000_0020);
        drive_pins(pins & ~((NP'(1) << 5) | (NP'(1) << 6)));
        check_all("R2 fall ignored");

        // R3 falling enable for pin 70
        mask_wr(1'b1, 2, 32'h0000_0040);
        drive_pins(pins | (NP'(1) << 70));
        check_all("R3 rise ignored");
        drive_pins(pins & ~(NP'(1) << 70));
        bus_rd(8'h50, d); check("R3 fall pin70", d, 32'h0000_0040);

        // R4 both edges for pin 33
        mask_wr(1'b0, 1, 32'h0000_0002);
        mask_wr(1'b1, 1, 32'h0000_0002);
        drive_pins(pins | (NP'(1) << 33));
        check_all("R4 rise");
        clr_wr(1, 32'h0000_0002);
        check_all("R4 cleared");
        drive_pins(pins & ~(NP'(1) << 33));
        bus_rd(8'h4C, d); check("R4 fall pin33", d, 32'h0000_0002);

        // R5 write zero, R6 selective clear
        for (int k = 0; k < 3; k++) clr_wr(k, 32'h0);
        check_all("R5");
        clr_wr(0, 32'h0000_0020);
        check_all("R6");
        bus_rd(8'h4C, d); check("R6 other word kept", d, 32'h0000_0002);

        // R11 status dead bits
        clr_wr(2, 32'hFFFE_0000);
        bus_rd(8'h50, d); check("R11 status word2", d, 32'h0000_0040);

        // R12 latency on pin 40
        mask_wr(1'b0, 1, 32'h0000_0102);
        @(negedge clk);
        pins[40] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        addr = 8'h4C; #1;
        check("R12 not after edge 2", {31'b0, rdata[8]}, 32'h0);
        @(negedge clk); #1;
        check("R12 set after edge 3", {31'b0, rdata[8]}, 32'h1);
        exp_stat[40] = 1'b1;
        repeat (2) @(negedge clk);

        // R7 event and clear in same cycle on pin 20
        mask_wr(1'b0, 0, 32'h0010_0000);
        mask_wr(1'b1, 0, 32'h0010_0000);
        drive_pins(pins | (NP'(1) << 20));
        @(negedge clk);
        pins[20] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 8'h48; wdata = 32'h0010_0000;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd(8'h48, d); check("R7 set wins", d & 32'h0010_0000, 32'h0010_0000);
        clr_wr(0, 32'h0010_0000);
        check_all("R7 later clear");

        // R8 and R9 interrupt mapping
        for (int k = 0; k < 3; k++) clr_wr(k, 32'hFFFF_FFFF);
        mask_wr(1'b0, 0, 32'h0000_0007);
        mask_wr(1'b0, 2, 32'h0001_0000);
        drive_pins(pins | NP'(1));
        check_all("R8 pin0");
        check("R8 pin0 line", {29'b0, irq0, irq1, irqs}, 32'h4);
        clr_wr(0, 32'h1);
        drive_pins(pins | (NP'(1) << 1));
        check("R8 pin1 line", {29'b0, irq0, irq1, irqs}, 32'h2);
        clr_wr(0, 32'h2);
        drive_pins(pins | (NP'(1) << 80));
        check("R9 pin80 line", {29'b0, irq0, irq1, irqs}, 32'h1);
        clr_wr(2, 32'h0001_0000);
        check("R9 released", {29'b0, irq0, irq1, irqs}, 32'h0);
        drive_pins(pins | (NP'(1) << 2));
        check_all("R9 pin2");

        // random traffic (R2, R3, R4, R6 mixed)
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 3; k++) begin
                mask_wr(1'b0, k, $urandom);
                mask_wr(1'b1, k, $urandom);
            end
            nv = NP'({$urandom, $urandom, $urandom});
            drive_pins(nv);
            check_all("R4 random events");
            clr_wr($urandom_range(0, 2), $urandom);
            check_all("R6 random clear");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule